// File: doc/BRIEF.md
# Serialized Interrupt Peripheral with Slot Routing

This block is the peripheral end of a one-wire serialized interrupt bus. A host controller frames each bus cycle with a start pulse, a train of three-clock slots and a stop pulse. The block drives the shared open-drain line low in every slot whose interrupt is pending. The interrupts come from a set of internal sources, each tied to a fixed slot number by a parameter, and from four external interrupt inputs. Each external input reaches the slot picked by its own 4-bit select field.

The block watches the line for start and stop pulses. It measures the stop pulse to learn which mode the next bus cycle uses. In continuous mode only the host may open a cycle. In quiet mode the block may open one itself with a single low clock, and it does so only when an interrupt level differs from the one it last sent. Every pin is plain control with no handshake: the line is sampled and driven on each rising clock edge, and the interrupt levels are taken as they are with no back-pressure.

Top module: `sirq_periph`

## Requirements
- R1: While `rst_n` is low, `sirq_oe` is 0. After reset the block is in continuous mode and does not drive the line until a host opens a cycle.
- R2: The first rising edge at which `sirq_in` is sampled high after a start pulse is edge k. The sample clock of slot n (n = 0..15) is the clock that begins at edge k + 3·n.
- R3: In the sample clock of a slot whose interrupt is active, the block drives low. In the next clock (recovery) it drives high, and only if it drove low in the sample clock. In the third clock (turnaround) it releases the line.
- R4: Internal source i is active high and uses a fixed slot set by parameter. The defaults are source 0 → slot 1, source 1 → slot 4, source 2 → slot 6 and source 3 → slot 12.
- R5: External input j is active high and goes to the slot held in `ext_slot_sel[4j+3:4j]`. A select value of 0 disables the input. Several external inputs that select the same slot are ORed.
- R6: A slot that belongs to an internal source ignores every external input routed to it, whatever level the internal source has.
- R7: A stop pulse that is sampled low on exactly 2 edges sets quiet mode for the next cycle. A stop pulse sampled low on any other count (3 or more) sets continuous mode.
- R8: In continuous mode the block never drives the line outside the slot frames.
- R9: In quiet mode the block drives exactly one low clock to request a cycle, and only when at least one slot's interrupt level differs from the level last sent in that slot. The earliest such clock begins at the second edge after the edge that first samples the stop pulse high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling and driving on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sirq_in | input | 1 | Sensed level of the shared line |
| sirq_oe | output | 1 | Drive enable for the shared line |
| sirq_out | output | 1 | Level driven while `sirq_oe` is 1 |
| int_irq | input | N_INT (4) | Internal interrupt levels, fixed slots |
| ext_irq | input | N_EXT (4) | External interrupt levels |
| ext_slot_sel | input | 4·N_EXT (16) | Slot select per external input, 4 bits each, 0 = off |

## Verification
The checker evaluates the following on every clock: the line is released during reset, the low-high-release shape of each slot drive, silence outside frames in continuous mode, the single-clock quiet request, and the hold-off right after a stop decode. Only the bench scenarios can show that each slot lands at its 3·n offset and that routing, disable and internal priority pick the right slots. The same applies to the stop width choosing the mode, and to a quiet request appearing only when an interrupt changed and landing on the exact clock of the earliest allowed start.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  // Bus-cycle tracker states
  typedef enum logic [2:0] {
    TRK_IDLE,    // waiting for a start pulse (or own request in quiet mode)
    TRK_REQ,     // driving the one-clock quiet-mode request
    TRK_START,   // inside the start pulse, waiting for the line to rise
    TRK_FRAMES,  // walking the slot frames
    TRK_STOPW,   // frames done, waiting for the stop pulse
    TRK_STOP     // measuring the stop pulse width
  } trk_state_e;

  // Three clocks of every slot
  typedef enum logic [1:0] {
    PH_SAMPLE,
    PH_RECOV,
    PH_TURN
  } slot_phase_e;

  // Stop pulse length (in low samples) that selects quiet mode
  localparam int QUIET_STOP_LEN = 2;

endpackage

// File: rtl/sirq_slot_map.sv
module sirq_slot_map #(
  parameter int N_INT     = 4,
  parameter int N_EXT     = 4,
  parameter int NUM_SLOTS = 16,
  parameter int SLOT_W    = $clog2(NUM_SLOTS),
  parameter logic [N_INT*SLOT_W-1:0] INT_SLOT_MAP = {4'd12, 4'd6, 4'd4, 4'd1}
) (
  input  logic [N_INT-1:0]        int_q_i,
  input  logic [N_EXT-1:0]        ext_q_i,
  input  logic [N_EXT*SLOT_W-1:0] ext_sel_i,
  output logic [NUM_SLOTS-1:0]    slot_vec_o
);

  // One combine cell per slot; internal ownership is static (parameter)
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic int_hit;
    logic int_own;
    logic ext_hit;

    always_comb begin
      int_hit = 1'b0;
      int_own = 1'b0;
      for (int i = 0; i < N_INT; i++) begin
        if (INT_SLOT_MAP[i*SLOT_W +: SLOT_W] == SLOT_W'(s)) begin
          int_own = 1'b1;
          int_hit = int_hit | int_q_i[i];
        end
      end
    end

    always_comb begin
      ext_hit = 1'b0;
      for (int j = 0; j < N_EXT; j++) begin
        // select value 0 means the input is switched off
        if ((ext_sel_i[j*SLOT_W +: SLOT_W] == SLOT_W'(s)) &&
            (ext_sel_i[j*SLOT_W +: SLOT_W] != '0)) begin
          ext_hit = ext_hit | ext_q_i[j];
        end
      end
    end

    assign slot_vec_o[s] = int_hit | (~int_own & ext_hit);
  end

endmodule

// File: rtl/sirq_frame_track.sv
module sirq_frame_track
  import sirq_pkg::*;
#(
  parameter int NUM_SLOTS  = 16,
  parameter int SLOT_W     = $clog2(NUM_SLOTS),
  parameter int HOLD_CLKS  = 1,
  parameter int STOP_CNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  input  logic              req_pend_i,
  output trk_state_e        state_o,
  output logic [SLOT_W-1:0] slot_o,
  output slot_phase_e       phase_o,
  output logic              quiet_o,
  output logic              stop_done_o
);

  localparam int HOLD_W = $clog2(HOLD_CLKS + 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [STOP_CNT_W-1:0] QUIET_CNT = STOP_CNT_W'(QUIET_STOP_LEN);

  trk_state_e            state_q;
  logic [SLOT_W-1:0]     slot_q;
  slot_phase_e           phase_q;
  logic [STOP_CNT_W-1:0] low_cnt_q;
  logic [HOLD_W-1:0]     hold_q;
  logic                  quiet_q;
  logic                  stop_done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= TRK_IDLE;
      slot_q      <= '0;
      phase_q     <= PH_SAMPLE;
      low_cnt_q   <= '0;
      hold_q      <= '0;
      quiet_q     <= 1'b0;
      stop_done_q <= 1'b0;
    end else begin
      stop_done_q <= 1'b0;
      case (state_q)
        TRK_IDLE: begin
          if (hold_q != '0) hold_q <= hold_q - 1'b1;
          if (!line_i) begin
            state_q <= TRK_START;
          end else if (quiet_q && (hold_q == '0) && req_pend_i) begin
            state_q <= TRK_REQ;
          end
        end
        TRK_REQ: begin
          state_q <= TRK_START;
        end
        TRK_START: begin
          if (line_i) begin
            state_q <= TRK_FRAMES;
            slot_q  <= '0;
            phase_q <= PH_SAMPLE;
          end
        end
        TRK_FRAMES: begin
          case (phase_q)
            PH_SAMPLE: phase_q <= PH_RECOV;
            PH_RECOV:  phase_q <= PH_TURN;
            default: begin
              phase_q <= PH_SAMPLE;
              if (slot_q == LAST_SLOT) state_q <= TRK_STOPW;
              else                     slot_q  <= slot_q + 1'b1;
            end
          endcase
        end
        TRK_STOPW: begin
          if (!line_i) begin
            state_q   <= TRK_STOP;
            low_cnt_q <= STOP_CNT_W'(1);
          end
        end
        TRK_STOP: begin
          if (!line_i) begin
            if (low_cnt_q != '1) low_cnt_q <= low_cnt_q + 1'b1;
          end else begin
            quiet_q     <= (low_cnt_q == QUIET_CNT);
            hold_q      <= HOLD_W'(HOLD_CLKS);
            stop_done_q <= 1'b1;
            state_q     <= TRK_IDLE;
          end
        end
        default: state_q <= TRK_IDLE;
      endcase
    end
  end

  assign state_o     = state_q;
  assign slot_o      = slot_q;
  assign phase_o     = phase_q;
  assign quiet_o     = quiet_q;
  assign stop_done_o = stop_done_q;

endmodule

// File: rtl/sirq_line_drive.sv
module sirq_line_drive
  import sirq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  trk_state_e           state_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  slot_phase_e          phase_i,
  input  logic [NUM_SLOTS-1:0] slot_vec_i,
  output logic                 oe_o,
  output logic                 out_o,
  output logic                 pend_o
);

  logic                 drove_q;
  logic [NUM_SLOTS-1:0] sent_q;
  logic                 in_sample;

  assign in_sample = (state_i == TRK_FRAMES) && (phase_i == PH_SAMPLE);

  // Remember what went out in each slot, and whether this slot drove low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drove_q <= 1'b0;
      sent_q  <= '0;
    end else if (in_sample) begin
      drove_q        <= slot_vec_i[slot_i];
      sent_q[slot_i] <= slot_vec_i[slot_i];
    end
  end

  always_comb begin
    oe_o  = 1'b0;
    out_o = 1'b1;
    if (state_i == TRK_REQ) begin
      oe_o  = 1'b1;
      out_o = 1'b0;
    end else if (state_i == TRK_FRAMES) begin
      if (phase_i == PH_SAMPLE && slot_vec_i[slot_i]) begin
        oe_o  = 1'b1;
        out_o = 1'b0;
      end else if (phase_i == PH_RECOV && drove_q) begin
        oe_o  = 1'b1;
        out_o = 1'b1;
      end
    end
  end

  assign pend_o = |(slot_vec_i ^ sent_q);

endmodule

// File: rtl/sirq_periph.sv
module sirq_periph
  import sirq_pkg::*;
#(
  parameter int N_INT     = 4,
  parameter int N_EXT     = 4,
  parameter int NUM_SLOTS = 16,
  parameter int HOLD_CLKS = 1,
  parameter logic [N_INT*$clog2(NUM_SLOTS)-1:0] INT_SLOT_MAP = {4'd12, 4'd6, 4'd4, 4'd1}
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  sirq_in,
  output logic                                  sirq_oe,
  output logic                                  sirq_out,
  input  logic [N_INT-1:0]                      int_irq,
  input  logic [N_EXT-1:0]                      ext_irq,
  input  logic [N_EXT*$clog2(NUM_SLOTS)-1:0]    ext_slot_sel
);

  localparam int SLOT_W = $clog2(NUM_SLOTS);

  logic [N_INT-1:0]     int_q;
  logic [N_EXT-1:0]     ext_q;
  logic [NUM_SLOTS-1:0] slot_vec;
  trk_state_e           trk_state;
  logic [SLOT_W-1:0]    cur_slot;
  slot_phase_e          cur_phase;
  logic                 quiet_mode;
  logic                 stop_done;
  logic                 req_pend;
  logic                 in_frames;

  // Capture interrupt levels on the bus clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q <= '0;
      ext_q <= '0;
    end else begin
      int_q <= int_irq;
      ext_q <= ext_irq;
    end
  end

  sirq_slot_map #(
    .N_INT(N_INT), .N_EXT(N_EXT), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W),
    .INT_SLOT_MAP(INT_SLOT_MAP)
  ) map_i (
    .int_q_i   (int_q),
    .ext_q_i   (ext_q),
    .ext_sel_i (ext_slot_sel),
    .slot_vec_o(slot_vec)
  );

  sirq_frame_track #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .HOLD_CLKS(HOLD_CLKS), .STOP_CNT_W(3)
  ) trk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_i     (sirq_in),
    .req_pend_i (req_pend),
    .state_o    (trk_state),
    .slot_o     (cur_slot),
    .phase_o    (cur_phase),
    .quiet_o    (quiet_mode),
    .stop_done_o(stop_done)
  );

  sirq_line_drive #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
  ) drv_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_i   (trk_state),
    .slot_i    (cur_slot),
    .phase_i   (cur_phase),
    .slot_vec_i(slot_vec),
    .oe_o      (sirq_oe),
    .out_o     (sirq_out),
    .pend_o    (req_pend)
  );

  assign in_frames = (trk_state == TRK_FRAMES);

endmodule

// File: rtl/sirq_periph_chk.sv
module sirq_periph_chk (
  input logic clk,
  input logic rst_n,
  input logic oe,
  input logic dout,
  input logic in_frames,
  input logic quiet,
  input logic stop_done
);

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RESET_RELEASE: assert (!oe); // R1
    end
  end

  AST_RECOV_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frames && oe && !dout) |=> (oe && dout)); // R3

  AST_HIGH_THEN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && dout) |=> !oe); // R3

  AST_CONT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!quiet && !in_frames) |-> !oe); // R8

  AST_REQ_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && !dout && !in_frames) |=> !oe); // R9

  AST_HOLDOFF_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |-> !oe); // R9

  AST_HOLDOFF_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |=> !oe); // R9

endmodule

bind sirq_periph sirq_periph_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .oe       (sirq_oe),
  .dout     (sirq_out),
  .in_frames(in_frames),
  .quiet    (quiet_mode),
  .stop_done(stop_done)
);

// File: tb/sirq_periph_tb_top.sv
`timescale 1ns/1ps
module sirq_periph_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_low;
  logic        line;
  logic        sirq_oe, sirq_out;
  logic [3:0]  int_irq, ext_irq;
  logic [15:0] ext_slot_sel;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  // wired-AND line with pull-up
  assign line = ~host_low & (sirq_oe ? sirq_out : 1'b1);

  sirq_periph dut_i (
    .clk(clk), .rst_n(rst_n), .sirq_in(line), .sirq_oe(sirq_oe), .sirq_out(sirq_out),
    .int_irq(int_irq), .ext_irq(ext_irq), .ext_slot_sel(ext_slot_sel)
  );

  // {int_irq, ext_irq, ext_slot_sel, expected slot vector}
  localparam logic [39:0] VECS [0:7] = '{
    {4'b0001, 4'b0000, 16'h0000, 16'h0002},  // R4 internal slot 1
    {4'b1010, 4'b0000, 16'h0000, 16'h1010},  // R4 slots 4 and 12
    {4'b0000, 4'b0001, 16'h0003, 16'h0008},  // R5 ext0 -> slot 3
    {4'b0000, 4'b1111, 16'hF972, 16'h8284},  // R5 four routes
    {4'b0000, 4'b0001, 16'h0006, 16'h0000},  // R6 slot 6 owned, internal idle
    {4'b0100, 4'b0101, 16'h0605, 16'h0060},  // R6 shared slot 6, ext0 slot 5
    {4'b0000, 4'b1111, 16'h0000, 16'h0000},  // R5 all disabled
    {4'b0000, 4'b1000, 16'hA0A0, 16'h0400}   // R5 two inputs share slot 10
  };

  task automatic check(input bit cond, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_start(input int n_low);
    @(negedge clk) host_low = 1'b1;
    repeat (n_low - 1) @(negedge clk);
    @(negedge clk) host_low = 1'b0;
  endtask

  task automatic host_stop(input int n_low);
    @(negedge clk) host_low = 1'b1;
    repeat (n_low - 1) @(negedge clk);
    @(negedge clk) host_low = 1'b0;
  endtask

  // Observe the 16 slots right after the start pulse is released
  task automatic observe(output logic [15:0] got, output bit shape_ok);
    got = '0;
    shape_ok = 1'b1;
    for (int s = 0; s < 16; s++) begin
      @(negedge clk);
      got[s] = ~line;
      @(negedge clk);
      if (got[s] != (sirq_oe && sirq_out)) shape_ok = 1'b0;
      if (!got[s] && sirq_oe) shape_ok = 1'b0;
      @(negedge clk);
      if (sirq_oe) shape_ok = 1'b0;
    end
  endtask

  task automatic watch_silent(input int n, output bit silent);
    silent = 1'b1;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (sirq_oe) silent = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1..: actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    bit          ok;
    bit          found;

    rst_n = 1'b0; host_low = 1'b0;
    int_irq = '0; ext_irq = '0; ext_slot_sel = '0;
    repeat (4) @(negedge clk);
    check(!sirq_oe, "R1 reset release", 32'(sirq_oe), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Table walk: continuous cycles (stop of 3 clocks)
    for (int v = 0; v < 8; v++) begin
      int_irq      = VECS[v][39:36];
      ext_irq      = VECS[v][35:32];
      ext_slot_sel = VECS[v][31:16];
      repeat (3) @(negedge clk);
      host_start(4);
      observe(got, ok);
      check(got == VECS[v][15:0], $sformatf("R2 R4 R5 R6 vector %0d", v),
            32'(got), 32'(VECS[v][15:0]));
      check(ok, $sformatf("R3 drive shape vector %0d", v), 32'(ok), 1);
      host_stop(3);
      repeat (4) @(negedge clk);
    end

    // R8 / R7: continuous after 3-clock stop, a change must not raise a request
    int_irq = '0; ext_irq = 4'b0001; ext_slot_sel = 16'h0003;
    watch_silent(12, ok);
    check(ok, "R8 R7 continuous silent", 32'(ok), 1);
    host_start(4);
    observe(got, ok);
    check(got == 16'h0008, "R5 ext0 slot 3", 32'(got), 32'h0008);
    host_stop(2);

    // R9: quiet, nothing changed -> silent
    watch_silent(12, ok);
    check(ok, "R9 quiet no change", 32'(ok), 1);

    // R9: quiet with change -> one request
    @(negedge clk) int_irq = 4'b0001;
    found = 1'b0;
    for (int c = 0; c < 10 && !found; c++) begin
      @(negedge clk);
      if (sirq_oe && !sirq_out) found = 1'b1;
    end
    check(found, "R9 quiet request raised", 32'(found), 1);
    host_start(3);
    observe(got, ok);
    check(got == 16'h000A, "R4 R5 quiet cycle vector", 32'(got), 32'h000A);
    int_irq = '0;
    host_stop(2);
    @(negedge clk);
    check(!sirq_oe, "R9 hold-off first clock", 32'(sirq_oe), 0);
    @(negedge clk);
    check(!sirq_oe, "R9 hold-off second clock", 32'(sirq_oe), 0);
    @(negedge clk);
    check(sirq_oe && !sirq_out, "R9 earliest request clock R7 quiet",
          32'({sirq_oe, sirq_out}), 32'b10);
    host_start(3);
    observe(got, ok);
    check(got == 16'h0008, "R9 cycle after request", 32'(got), 32'h0008);
    host_stop(3);
    repeat (4) @(negedge clk);

    // R1: reset in the middle of a frame, then continuous again
    int_irq = 4'b0010;
    repeat (3) @(negedge clk);
    host_start(4);
    repeat (13) @(negedge clk);
    check(sirq_oe && !sirq_out, "R2 slot 4 sample clock", 32'({sirq_oe, sirq_out}), 32'b10);
    #1 rst_n = 1'b0;
    #1 check(!sirq_oe, "R1 reset mid-frame", 32'(sirq_oe), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    watch_silent(10, ok);
    check(ok, "R1 continuous after reset", 32'(ok), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule